// File: doc/BRIEF.md
# Controller Status Indicator Sequencer

This block turns the internal condition of a controller into the pattern shown on its front-panel lights. The lights are a health light, a two-colour run light (green and amber), a fault light, an override light and one activity light per serial port. Inputs report power, the start-up phases, the operating mode, fault conditions, a pending fault-clear window, an active override and per-port activity strobes. An internal prescaler makes a fast blink phase and a slow blink phase. Several conditions share the same pair of lights, so they are told apart by blink rate, by colour, and by the health and run lights blinking together.

A state machine chooses one display state per clock from a fixed priority order. The states are `ST_DARK`, `ST_BOOT`, `ST_DIAG_FAIL`, `ST_DIAG`, `ST_CONFIG`, `ST_CPU_BAD`, `ST_RUN`, `ST_STOP_SCAN`, `ST_STOP_IDLE`, `ST_FAULT` and `ST_FAULT_CLR`. Any state can move to any other state in one clock, and it goes to the highest-priority condition that is present. Loss of power always leads to `ST_DARK`. A set boot flag leads to `ST_BOOT`. After that, in order, a diagnostic failure leads to `ST_DIAG_FAIL`, running diagnostics to `ST_DIAG`, I/O configuration to `ST_CONFIG`, and a bad CPU to `ST_CPU_BAD`. Otherwise the mode field picks one of the four operating states. From `ST_FAULT`, a fault-clear window together with a fatal fault moves the machine to `ST_FAULT_CLR`, and it returns to `ST_FAULT` when either input drops. Activity strobes are stretched so that each one stays visible. The blink rates come from parameters: with `FAST_HALF` at one sixteenth of the clock rate and `SLOW_MULT` at 8, the fast blink is about 8 Hz and the slow blink about 1 Hz.

Top module: `status_led_top`

## Requirements
- R1: While `pwr_good` is low, every light is off, including the override and port lights. Reset also leaves every light off.
- R2: While diagnostics run (`diag_run`=1), the health light blinks at the fast rate, with a half period of `FAST_HALF` clocks. The run and fault lights stay off.
- R3: While I/O modules are being configured (`cfg_io`=1), the health light blinks at the slow rate, with a half period of `FAST_HALF*SLOW_MULT` clocks.
- R4: While `boot_wait`=1, the health light and the green run light blink at the slow rate in the same phase, and the amber light stays off.
- R5: While `diag_fault`=1, the health light is off and the fault light blinks at the fast rate.
- R6: With no start-up condition present and `cpu_ok` low, the health, run and fault lights are all off.
- R7: In a healthy state, `run_mode`=0 (Run) gives a steady health light, a steady green run light and no fault light.
- R8: `run_mode`=1 (Stop with I/O scan) gives a steady health light and a steady amber run light.
- R9: `run_mode`=2 (Stop without I/O scan) gives a steady health light with the run light off in both colours.
- R10: `run_mode`=3 (Stop/Fault) gives a steady fault light with the run light off. If `clr_window` and `fatal_fault` are both high, the green run light instead blinks fast while the fault light stays on.
- R11: While powered, the override light follows `force_on`.
- R12: Each single-cycle strobe on `port_act[i]` lights `led_port[i]` from the next cycle for exactly `2*FAST_HALF` clocks after the last strobe. The other ports' lights are not affected.
- R13: The green and amber run lights are never on together.
- R14: Conditions are ranked in this order: power, boot, diagnostic failure, diagnostics running, configuration, CPU health, then mode. For example, `diag_run` and `cfg_io` together give the fast blink.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply is present |
| diag_run | input | 1 | Power-up diagnostics in progress |
| diag_fault | input | 1 | Fatal fault found by power-up diagnostics |
| cfg_io | input | 1 | I/O modules being configured |
| boot_wait | input | 1 | Boot mode, waiting for a firmware load |
| cpu_ok | input | 1 | CPU healthy |
| run_mode | input | 2 | 0 Run, 1 Stop with scan, 2 Stop without scan, 3 Stop/Fault |
| fatal_fault | input | 1 | A fatal fault is present |
| clr_window | input | 1 | Fault-clear window is open |
| force_on | input | 1 | An override is active |
| port_act | input | NPORTS | Per-port activity strobes |
| led_ok | output | 1 | Health light |
| led_run_grn | output | 1 | Run light, green |
| led_run_amb | output | 1 | Run light, amber |
| led_fault | output | 1 | Fault light |
| led_force | output | 1 | Override light |
| led_port | output | NPORTS | Per-port activity lights |

## Verification
The hardest conditions to tell apart are the ones that differ only in how a light moves over time: a fast blink, a slow blink, the boot state where two lights blink in the same phase, and the fault-clear blink on the green run light. A single sample cannot separate them. The bench therefore reduces the prescaler to a few clocks and watches each light over a window long enough to hold several slow half-periods. It counts level changes and compares the health and green lights sample by sample. The priority cases are reached by raising several condition inputs at once.

// File: rtl/status_led_pkg.sv
package status_led_pkg;
    typedef enum logic [1:0] {
        MODE_RUN        = 2'd0,
        MODE_STOP_SCAN  = 2'd1,
        MODE_STOP_IDLE  = 2'd2,
        MODE_STOP_FAULT = 2'd3
    } op_mode_e;

    typedef enum logic [3:0] {
        ST_DARK,
        ST_BOOT,
        ST_DIAG_FAIL,
        ST_DIAG,
        ST_CONFIG,
        ST_CPU_BAD,
        ST_RUN,
        ST_STOP_SCAN,
        ST_STOP_IDLE,
        ST_FAULT,
        ST_FAULT_CLR
    } disp_state_e;
endpackage

// File: rtl/blink_prescaler.sv
module blink_prescaler #(
    parameter int FAST_HALF = 12_500_000,
    parameter int SLOW_MULT = 8
) (
    input  logic clk,
    input  logic rst,
    output logic fast_ph,
    output logic slow_ph
);
    localparam int FW = (FAST_HALF > 1) ? $clog2(FAST_HALF) : 1;
    localparam int SW = (SLOW_MULT > 1) ? $clog2(SLOW_MULT) : 1;

    logic [FW-1:0] div_q;
    logic [SW-1:0] mul_q;
    logic          tick;

    assign tick = (div_q == FW'(FAST_HALF - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            mul_q   <= '0;
            fast_ph <= 1'b0;
            slow_ph <= 1'b0;
        end else begin
            div_q <= tick ? '0 : div_q + 1'b1;
            if (tick) begin
                fast_ph <= ~fast_ph;
                if (mul_q == SW'(SLOW_MULT - 1)) begin
                    mul_q   <= '0;
                    slow_ph <= ~slow_ph;
                end else begin
                    mul_q <= mul_q + 1'b1;
                end
            end
        end
    end

    // R3: a slow edge always coincides with a fast edge
    p_slow_on_fast_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(slow_ph) |-> !$stable(fast_ph));
endmodule

// File: rtl/activity_stretch.sv
module activity_stretch #(
    parameter int HOLD = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic busy
);
    localparam int HW = $clog2(HOLD + 1);

    logic [HW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)              left_q <= '0;
        else if (strobe)      left_q <= HW'(HOLD);
        else if (left_q != 0) left_q <= left_q - 1'b1;
    end

    assign busy = (left_q != '0);

    p_strobe_lights_r12: assert property (@(posedge clk) disable iff (rst)
        strobe |=> busy);
endmodule

// File: rtl/led_mode_fsm.sv
module led_mode_fsm
    import status_led_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_good,
    input  logic       diag_run,
    input  logic       diag_fault,
    input  logic       cfg_io,
    input  logic       boot_wait,
    input  logic       cpu_ok,
    input  logic [1:0] run_mode,
    input  logic       fatal_fault,
    input  logic       clr_window,
    input  logic       fast_ph,
    input  logic       slow_ph,
    output logic       ok,
    output logic       run_g,
    output logic       run_a,
    output logic       fault,
    output logic       lit
);
    disp_state_e state_q, state_d;
    op_mode_e    mode;

    assign mode = op_mode_e'(run_mode);

    always_comb begin
        if (!pwr_good)        state_d = ST_DARK;
        else if (boot_wait)   state_d = ST_BOOT;
        else if (diag_fault)  state_d = ST_DIAG_FAIL;
        else if (diag_run)    state_d = ST_DIAG;
        else if (cfg_io)      state_d = ST_CONFIG;
        else if (!cpu_ok)     state_d = ST_CPU_BAD;
        else begin
            unique case (mode)
                MODE_RUN:        state_d = ST_RUN;
                MODE_STOP_SCAN:  state_d = ST_STOP_SCAN;
                MODE_STOP_IDLE:  state_d = ST_STOP_IDLE;
                MODE_STOP_FAULT: state_d = (clr_window && fatal_fault)
                                           ? ST_FAULT_CLR : ST_FAULT;
                default:         state_d = ST_FAULT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_DARK;
        else     state_q <= state_d;
    end

    always_comb begin
        ok    = 1'b0;
        run_g = 1'b0;
        run_a = 1'b0;
        fault = 1'b0;
        lit   = 1'b1;
        unique case (state_q)
            ST_DARK:      lit   = 1'b0;
            ST_BOOT: begin
                ok    = slow_ph;
                run_g = slow_ph;
            end
            ST_DIAG_FAIL: fault = fast_ph;
            ST_DIAG:      ok    = fast_ph;
            ST_CONFIG:    ok    = slow_ph;
            ST_CPU_BAD:   ok    = 1'b0;
            ST_RUN: begin
                ok    = 1'b1;
                run_g = 1'b1;
            end
            ST_STOP_SCAN: begin
                ok    = 1'b1;
                run_a = 1'b1;
            end
            ST_STOP_IDLE: ok = 1'b1;
            ST_FAULT: begin
                ok    = 1'b1;
                fault = 1'b1;
            end
            ST_FAULT_CLR: begin
                ok    = 1'b1;
                fault = 1'b1;
                run_g = fast_ph;
            end
            default:      lit = 1'b0;
        endcase
    end

    p_stop_idle_dark_run_r9: assert property (@(posedge clk) disable iff (rst)
        (pwr_good && !boot_wait && !diag_fault && !diag_run && !cfg_io && cpu_ok
         && run_mode == 2'd2) |=> (ok && !run_g && !run_a));
    p_stop_fault_lamp_r10: assert property (@(posedge clk) disable iff (rst)
        (pwr_good && !boot_wait && !diag_fault && !diag_run && !cfg_io && cpu_ok
         && run_mode == 2'd3) |=> fault);
endmodule

// File: rtl/status_led_top.sv
module status_led_top #(
    parameter int NPORTS    = 2,
    parameter int FAST_HALF = 12_500_000,
    parameter int SLOW_MULT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_good,
    input  logic              diag_run,
    input  logic              diag_fault,
    input  logic              cfg_io,
    input  logic              boot_wait,
    input  logic              cpu_ok,
    input  logic [1:0]        run_mode,
    input  logic              fatal_fault,
    input  logic              clr_window,
    input  logic              force_on,
    input  logic [NPORTS-1:0] port_act,
    output logic              led_ok,
    output logic              led_run_grn,
    output logic              led_run_amb,
    output logic              led_fault,
    output logic              led_force,
    output logic [NPORTS-1:0] led_port
);
    localparam int HOLD = 2 * FAST_HALF;

    logic fast_ph, slow_ph, lit;
    logic [NPORTS-1:0] busy;

    blink_prescaler #(.FAST_HALF(FAST_HALF), .SLOW_MULT(SLOW_MULT)) u_presc (
        .clk(clk), .rst(rst), .fast_ph(fast_ph), .slow_ph(slow_ph));

    led_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .diag_run(diag_run),
        .diag_fault(diag_fault), .cfg_io(cfg_io), .boot_wait(boot_wait),
        .cpu_ok(cpu_ok), .run_mode(run_mode), .fatal_fault(fatal_fault),
        .clr_window(clr_window), .fast_ph(fast_ph), .slow_ph(slow_ph),
        .ok(led_ok), .run_g(led_run_grn), .run_a(led_run_amb),
        .fault(led_fault), .lit(lit));

    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        activity_stretch #(.HOLD(HOLD)) u_str (
            .clk(clk), .rst(rst), .strobe(port_act[i]), .busy(busy[i]));
        assign led_port[i] = busy[i] & lit;
    end

    assign led_force = force_on & lit;

    p_colours_exclusive_r13: assert property (@(posedge clk) disable iff (rst)
        $onehot0({led_run_grn, led_run_amb}));
    p_dark_when_unpowered_r1: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> (!led_ok && !led_run_grn && !led_run_amb && !led_fault
                       && !led_force && led_port == '0));
    p_boot_same_phase_r4: assert property (@(posedge clk) disable iff (rst)
        (pwr_good && boot_wait) |=> (led_ok == led_run_grn && !led_run_amb));
endmodule

// File: tb/tb_status_led_top.sv
`timescale 1ns/1ps
module tb_status_led_top;
    localparam int NP = 2;
    localparam int FH = 4;
    localparam int SM = 8;
    localparam int WIN = 128;

    localparam int P_OFF = 0, P_ON = 1, P_FAST = 2, P_SLOW = 3, P_BAD = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_good = 0, diag_run = 0, diag_fault = 0, cfg_io = 0, boot_wait = 0;
    logic cpu_ok = 0, fatal_fault = 0, clr_window = 0, force_on = 0;
    logic [1:0] run_mode = 2'd0;
    logic [NP-1:0] port_act = '0;
    logic led_ok, led_run_grn, led_run_amb, led_fault, led_force;
    logic [NP-1:0] led_port;

    int checks = 0;
    int fails  = 0;
    int pat_ok, pat_g, pat_a, pat_f, phase_miss;

    always #2.5 clk = ~clk;

    status_led_top #(.NPORTS(NP), .FAST_HALF(FH), .SLOW_MULT(SM)) dut (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .diag_run(diag_run),
        .diag_fault(diag_fault), .cfg_io(cfg_io), .boot_wait(boot_wait),
        .cpu_ok(cpu_ok), .run_mode(run_mode), .fatal_fault(fatal_fault),
        .clr_window(clr_window), .force_on(force_on), .port_act(port_act),
        .led_ok(led_ok), .led_run_grn(led_run_grn), .led_run_amb(led_run_amb),
        .led_fault(led_fault), .led_force(led_force), .led_port(led_port));

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int classify(input int changes, input int highs);
        if (changes == 0) return (highs > 0) ? P_ON : P_OFF;
        if (changes >= 28) return P_FAST;
        if (changes >= 3 && changes <= 5) return P_SLOW;
        return P_BAD;
    endfunction

    task automatic set_cond(input logic pg, input logic bw, input logic df,
                            input logic dr, input logic ci, input logic co,
                            input logic [1:0] m, input logic ff, input logic cw);
        @(negedge clk);
        pwr_good = pg; boot_wait = bw; diag_fault = df; diag_run = dr;
        cfg_io = ci; cpu_ok = co; run_mode = m; fatal_fault = ff; clr_window = cw;
        repeat (3) @(negedge clk);
    endtask

    task automatic observe();
        int c_ok = 0, c_g = 0, c_a = 0, c_f = 0;
        int h_ok = 0, h_g = 0, h_a = 0, h_f = 0;
        logic p_ok = led_ok, p_g = led_run_grn, p_a = led_run_amb, p_f = led_fault;
        phase_miss = 0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (led_ok != p_ok) c_ok++;
            if (led_run_grn != p_g) c_g++;
            if (led_run_amb != p_a) c_a++;
            if (led_fault != p_f) c_f++;
            h_ok += int'(led_ok); h_g += int'(led_run_grn);
            h_a += int'(led_run_amb); h_f += int'(led_fault);
            if (led_ok != led_run_grn) phase_miss++;
            if (led_run_grn && led_run_amb) phase_miss += 1000;
            p_ok = led_ok; p_g = led_run_grn; p_a = led_run_amb; p_f = led_fault;
        end
        pat_ok = classify(c_ok, h_ok);
        pat_g  = classify(c_g, h_g);
        pat_a  = classify(c_a, h_a);
        pat_f  = classify(c_f, h_f);
    endtask

    task automatic expect4(input string req, input int eo, input int eg, input int ea, input int ef);
        observe();
        check(req, "ok pattern", pat_ok, eo);
        check(req, "green pattern", pat_g, eg);
        check(req, "amber pattern", pat_a, ea);
        check(req, "fault pattern", pat_f, ef);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "reset lights", int'({led_ok, led_run_grn, led_run_amb, led_fault, led_force, led_port}), 0);
    endtask

    task automatic t_dark();
        set_cond(0, 1, 0, 1, 0, 1, 2'd0, 0, 0);
        force_on = 1'b1; port_act = 2'b11;
        @(negedge clk); port_act = '0;
        expect4("R1", P_OFF, P_OFF, P_OFF, P_OFF);
        check("R1", "force unpowered", int'(led_force), 0);
        check("R1", "ports unpowered", int'(led_port), 0);
        force_on = 1'b0;
    endtask

    task automatic t_diag();
        set_cond(1, 0, 0, 1, 0, 1, 2'd0, 0, 0);
        expect4("R2", P_FAST, P_OFF, P_OFF, P_OFF);
    endtask

    task automatic t_config();
        set_cond(1, 0, 0, 0, 1, 1, 2'd0, 0, 0);
        expect4("R3", P_SLOW, P_OFF, P_OFF, P_OFF);
    endtask

    task automatic t_boot();
        set_cond(1, 1, 1, 1, 1, 0, 2'd1, 0, 0);
        expect4("R4", P_SLOW, P_SLOW, P_OFF, P_OFF);
        check("R4", "ok/green phase mismatches", phase_miss, 0);
    endtask

    task automatic t_diag_fail();
        set_cond(1, 0, 1, 1, 0, 1, 2'd0, 0, 0);
        expect4("R5", P_OFF, P_OFF, P_OFF, P_FAST);
    endtask

    task automatic t_cpu_bad();
        set_cond(1, 0, 0, 0, 0, 0, 2'd0, 0, 0);
        expect4("R6", P_OFF, P_OFF, P_OFF, P_OFF);
    endtask

    task automatic t_modes();
        set_cond(1, 0, 0, 0, 0, 1, 2'd0, 0, 0);
        expect4("R7", P_ON, P_ON, P_OFF, P_OFF);
        set_cond(1, 0, 0, 0, 0, 1, 2'd1, 0, 0);
        expect4("R8", P_ON, P_OFF, P_ON, P_OFF);
        check("R13", "green with amber", phase_miss >= 1000 ? 1 : 0, 0);
        set_cond(1, 0, 0, 0, 0, 1, 2'd2, 0, 0);
        expect4("R9", P_ON, P_OFF, P_OFF, P_OFF);
    endtask

    task automatic t_fault();
        set_cond(1, 0, 0, 0, 0, 1, 2'd3, 1, 0);
        expect4("R10", P_ON, P_OFF, P_OFF, P_ON);
        set_cond(1, 0, 0, 0, 0, 1, 2'd3, 1, 1);
        expect4("R10", P_ON, P_FAST, P_OFF, P_ON);
        set_cond(1, 0, 0, 0, 0, 1, 2'd3, 0, 1);
        expect4("R10", P_ON, P_OFF, P_OFF, P_ON);
    endtask

    task automatic t_priority();
        set_cond(1, 0, 0, 1, 1, 0, 2'd0, 0, 0);
        expect4("R14", P_FAST, P_OFF, P_OFF, P_OFF);
        set_cond(1, 0, 0, 0, 1, 0, 2'd1, 0, 0);
        expect4("R14", P_SLOW, P_OFF, P_OFF, P_OFF);
    endtask

    task automatic t_force();
        set_cond(1, 0, 0, 0, 0, 1, 2'd0, 0, 0);
        force_on = 1'b1;
        @(negedge clk);
        check("R11", "force on", int'(led_force), 1);
        force_on = 1'b0;
        @(negedge clk);
        check("R11", "force off", int'(led_force), 0);
    endtask

    task automatic t_port();
        int on_cnt = 0;
        int other  = 0;
        set_cond(1, 0, 0, 0, 0, 1, 2'd0, 0, 0);
        port_act[0] = 1'b1;
        @(negedge clk);
        port_act[0] = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (led_port[0]) on_cnt++;
            if (led_port[1]) other++;
            @(negedge clk);
        end
        check("R12", "port0 lit cycles", on_cnt, 2 * FH);
        check("R12", "port1 disturbed", other, 0);
        port_act[1] = 1'b1;
        @(negedge clk);
        port_act[1] = 1'b0;
        repeat (FH) @(negedge clk);
        port_act[1] = 1'b1;
        @(negedge clk);
        port_act[1] = 1'b0;
        on_cnt = 0;
        for (int i = 0; i < 40; i++) begin
            if (led_port[1]) on_cnt++;
            @(negedge clk);
        end
        check("R12", "port1 retrigger cycles", on_cnt, 2 * FH);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_dark();
        t_diag();
        t_config();
        t_boot();
        t_diag_fail();
        t_cpu_bad();
        t_modes();
        t_fault();
        t_priority();
        t_force();
        t_port();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule